// File: doc/BRIEF.md
# Two-Phase Bi-Level Boost Timer

This block drives the high-voltage boost enables of a two-phase unipolar stepper drive. The phase sequencer sends a one-cycle strobe on a phase's trigger line each time that phase changes state. The matching one-shot then holds that phase's boost enable high for a fixed number of clock cycles. During that time the winding sees the raised supply, so its current climbs quickly. When the time runs out the enable drops and the winding falls back to its normal supply.

Both one-shots read one shared 16-bit duration input. This input takes the place of the common external timing network. A phase copies the duration only at the moment it is triggered. An inhibit input clears both one-shots and forces both enables low at once. The asynchronous active-low reset does the same.

Top module: `bilevel_boost_timer`

## Requirements
- R1: While rst_ni is low, boost_o is 2'b00. After reset is released, no enable rises until a trigger arrives.
- R2: Bit 0 of trig_i and boost_o belongs to phase A, and bit 1 belongs to phase B. A trigger sampled at a clock edge, with inhibit low and dur_i = D > 0, makes that phase's boost_o bit high for exactly D cycles, starting in the cycle after that edge. D = 1 gives a single-cycle pulse.
- R3: The two phases are independent. A trigger on one phase never changes the other phase's enable, and both phases may be triggered in the same cycle.
- R4: A trigger that arrives while a phase's pulse is still running reloads that phase to the full current duration. The pulse then lasts D cycles counted from the new trigger.
- R5: A trigger with dur_i = 0 gives no boost. If that phase was already boosting, its pulse ends in the cycle after the trigger.
- R6: While inhibit_i is high, both boost_o bits are low in that same cycle, both timers are cleared, and triggers are ignored. After inhibit_i falls, no pulse resumes until a new trigger arrives.
- R7: A change of dur_i while a pulse is running does not change that pulse's length. The new value is used from the next trigger on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inhibit_i | input | 1 | Clears both timers and forces both enables low |
| dur_i | input | 16 | Shared boost on-time in clock cycles; 0 disables boosting |
| trig_i | input | 2 | Per-phase change strobe, bit 0 = phase A, bit 1 = phase B |
| boost_o | output | 2 | Per-phase boost enable, bit 0 = phase A, bit 1 = phase B |

## Verification
The bench checks the length of every pulse cycle by cycle, so an off-by-one in the counter shows up as a pulse that is one cycle long or short. This includes the single-cycle case, D = 1.

Several sequences are aimed at specific mistakes:
- A retrigger in the middle of a pulse catches a design that ignores the retrigger or adds the new duration to the remaining count.
- A zero-duration trigger during a running pulse catches a design that lets the old pulse continue.
- Changing dur_i in the middle of a pulse catches a design that reads the duration live instead of copying it at the trigger.
- Asserting inhibit in the middle of a pulse, triggering during inhibit, and then releasing it catches an enable that lags by a cycle, a pulse that resumes after release, and a trigger that leaks through.
- Triggering the phases on their own and together catches crossed phase bits.

// File: rtl/boost_pkg.sv
package boost_pkg;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned N_PHASE = 2;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/boost_oneshot.sv
module boost_oneshot #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             active_o
);
  logic [CNT_W-1:0] cnt_q;

  // the duration is copied only on a trigger; a trigger always reloads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (trig_i)         cnt_q <= dur_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/bilevel_boost_timer.sv
module bilevel_boost_timer
  import boost_pkg::*;
#(
  parameter int unsigned DUR_W = CNT_W,
  parameter int unsigned NPH   = N_PHASE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inhibit_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic [NPH-1:0]   trig_i,
  output logic [NPH-1:0]   boost_o
);
  logic [NPH-1:0] active;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    boost_oneshot #(.CNT_W(DUR_W)) u_shot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (inhibit_i),
      .trig_i   (trig_i[p]),
      .dur_i    (dur_i),
      .active_o (active[p])
    );
  end

  // inhibit gates the enables combinationally so they drop in the same cycle
  assign boost_o = active & {NPH{~inhibit_i}};
endmodule

// File: rtl/boost_timer_chk.sv
module boost_timer_chk #(
  parameter int unsigned DUR_W = 16,
  parameter int unsigned NPH   = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             inhibit_i,
  input logic [DUR_W-1:0] dur_i,
  input logic [NPH-1:0]   trig_i,
  input logic [NPH-1:0]   boost_o
);
  always_comb begin
    if (rst_ni === 1'b0) assert_reset_clear_R1: assert (boost_o == '0);
  end

  assert_inhibit_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |-> (boost_o == '0));

  for (genvar p = 0; p < NPH; p++) begin : g_chk
    assert_trig_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_i[p] && !inhibit_i && dur_i != '0) |=> (boost_o[p] || inhibit_i));

    assert_zero_dur_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_i[p] && dur_i == '0) |=> !boost_o[p]);

    assert_rise_needs_trig_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(boost_o[p]) |-> ($past(trig_i[p]) && !$past(inhibit_i)));
  end
endmodule

bind bilevel_boost_timer boost_timer_chk #(.DUR_W(DUR_W), .NPH(NPH)) u_chk (.*);

// File: tb/bilevel_boost_timer_test.sv
module bilevel_boost_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inh = 1'b0;
  logic [15:0] dur = '0;
  logic [1:0]  trig = '0;
  logic [1:0]  boost;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int rem[2] = '{0, 0};

  typedef struct { logic [1:0] exp; string req; } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  bilevel_boost_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .inhibit_i(inh),
    .dur_i(dur), .trig_i(trig), .boost_o(boost)
  );

  // driver: drive one cycle of inputs, push expected outputs, advance the model
  task automatic cyc(input logic [1:0] t, input int d, input bit ih, input string req);
    item_t it;
    @(negedge clk);
    trig = t; dur = 16'(d); inh = ih;
    for (int p = 0; p < 2; p++) it.exp[p] = !ih && (rem[p] > 0);
    it.req = req;
    q.push_back(it);
    for (int p = 0; p < 2; p++) begin
      if (ih)        rem[p] = 0;
      else if (t[p]) rem[p] = d;
      else if (rem[p] > 0) rem[p]--;
    end
  endtask

  task automatic idle(input int n, input int d, input string req);
    for (int i = 0; i < n; i++) cyc(2'b00, d, 1'b0, req);
  endtask

  // monitor
  always @(negedge clk) begin
    #2;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (boost !== it.exp) begin
        fails++;
        $display("FAIL %s: boost_o=%b expected %b at %0t", it.req, boost, it.exp, $time);
      end
    end
  end

  initial begin
    #1;
    checks++;
    if (boost !== 2'b00) begin
      fails++; $display("FAIL R1: boost_o=%b expected 00 in reset", boost);
    end
    #30 rst_n = 1'b1;
    idle(3, 4, "R1");
    // R2 phase A, D=5; phase B stays low (R3)
    cyc(2'b01, 5, 1'b0, "R2");
    idle(8, 5, "R2/R3");
    // R2 boundary D=1 on phase B
    cyc(2'b10, 1, 1'b0, "R2");
    idle(4, 1, "R2");
    // R3 both phases together, then phase B alone mid-pulse of A
    cyc(2'b11, 4, 1'b0, "R3");
    idle(2, 4, "R3");
    cyc(2'b10, 6, 1'b0, "R3");
    idle(8, 6, "R3");
    // R4 retrigger phase A mid-pulse
    cyc(2'b01, 5, 1'b0, "R4");
    idle(3, 5, "R4");
    cyc(2'b01, 5, 1'b0, "R4");
    idle(8, 5, "R4");
    // R5 zero duration: no boost, and truncation of running pulse
    cyc(2'b11, 0, 1'b0, "R5");
    idle(3, 0, "R5");
    cyc(2'b11, 7, 1'b0, "R5");
    idle(2, 7, "R5");
    cyc(2'b01, 0, 1'b0, "R5");
    idle(7, 0, "R5");
    // R7 duration change mid-pulse, then next trigger uses new value
    cyc(2'b10, 3, 1'b0, "R7");
    idle(1, 3, "R7");
    idle(6, 9, "R7");
    cyc(2'b10, 2, 1'b0, "R7");
    idle(4, 2, "R7");
    // R6 inhibit mid-pulse, trigger while inhibited, release
    cyc(2'b11, 10, 1'b0, "R6");
    idle(2, 10, "R6");
    cyc(2'b00, 10, 1'b1, "R6");
    cyc(2'b11, 10, 1'b1, "R6");
    cyc(2'b00, 10, 1'b1, "R6");
    idle(5, 10, "R6");
    cyc(2'b01, 2, 1'b0, "R6");
    idle(4, 2, "R6");
    @(negedge clk); #5;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule